// File: doc/BRIEF.md
# Convolution-to-Matrix-Multiply Operand Address Sequencer

This block turns a three-dimensional convolution over an already padded input volume into the operand fetch order of a tiled matrix multiply. The output positions form the rows of the multiply: batch index, then output depth, height and width. The kernel taps form its columns: input channel, then kernel depth, height and width. After a start pulse the block walks every output tile in a grouped, cache-friendly order. Inside each tile it walks the reduction dimension in fixed-size steps. For every (row, column) pair of a step it emits one beat that carries the linear address of the matching input element.

A beat also tells whether the pair lies inside the real problem. Pairs in the ragged edge of a tile carry a clear element flag and a zero address, and the consumer treats them as zero operands. Memory, the multiply-accumulate datapath and the padding of the input are not part of the block. The configuration is captured when the start pulse is taken, so the ports may change after that. Tile sizes and the group size are parameters and must be powers of two.

Top module: `igemm_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `done` are 0 until a start pulse is taken.
- R2: A start pulse seen while idle captures every configuration port. `out_valid` is 0 in the cycle after the start edge and 1 in the cycle after that. Start pulses and configuration changes while the block is running have no effect on the stream.
- R3: Tiles are visited in this order. Let grid_m = ceil(M/BLOCK_M) and grid_n = ceil(Cout/BLOCK_N). Slot p gives row tile bm = (p / (8·grid_n))·8 + (p mod 8) and column tile bn = (p mod (8·grid_n)) / 8. Slots run from 0 to ceil(grid_m/8)·8·grid_n − 1, and slots with bm ≥ grid_m are skipped. `out_tile_m` and `out_tile_n` carry bm and bn.
- R4: Each tile takes ceil(K/BLOCK_K) reduction steps. Within a step, `out_m_local` runs from 0 to BLOCK_M−1 as the outer loop and `out_k_local` runs from 0 to BLOCK_K−1 as the inner loop. A tile therefore has BLOCK_M·BLOCK_K·ceil(K/BLOCK_K) beats.
- R5: The row index is m = bm·BLOCK_M + m_local. It splits into n = m / (OD·OH·OW), and then od, oh and ow by division and remainder over OH·OW and OW.
- R6: The column index is k = step·BLOCK_K + k_local. It splits into c = k / (kD·kH·kW), and then kd, kh and kw by division and remainder over kH·kW and kW.
- R7: For a valid element, `out_addr` = ((((n·Cin + c)·Dp + id)·Hp + ih)·Wp + iw), where id = od·sd + kd·dd, ih = oh·sh + kh·dh and iw = ow·sw + kw·dw.
- R8: `out_elem_ok` is 1 exactly when m < M and k < K. When it is 0, `out_addr` is 0.
- R9: A beat is accepted when `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, every output holds its value.
- R10: `done` is 1 for exactly one cycle, the cycle right after the last beat is accepted. `out_valid` is 0 in that cycle.
- R11: M = batch·OD·OH·OW and K = Cin·kD·kH·kW, both computed from the captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cfg_batch | input | DIM_W | Batch count |
| cfg_cin | input | DIM_W | Input channels |
| cfg_cout | input | DIM_W | Output channels (column extent of the multiply) |
| cfg_dp | input | DIM_W | Padded input depth |
| cfg_hp | input | DIM_W | Padded input height |
| cfg_wp | input | DIM_W | Padded input width |
| cfg_kd | input | DIM_W | Kernel depth |
| cfg_kh | input | DIM_W | Kernel height |
| cfg_kw | input | DIM_W | Kernel width |
| cfg_sd | input | DIM_W | Stride in depth |
| cfg_sh | input | DIM_W | Stride in height |
| cfg_sw | input | DIM_W | Stride in width |
| cfg_dd | input | DIM_W | Dilation in depth |
| cfg_dh | input | DIM_W | Dilation in height |
| cfg_dw | input | DIM_W | Dilation in width |
| cfg_od | input | DIM_W | Output depth |
| cfg_oh | input | DIM_W | Output height |
| cfg_ow | input | DIM_W | Output width |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_addr | output | ADDR_W | Linear input address, 0 for an invalid element |
| out_elem_ok | output | 1 | Element lies inside M and K |
| out_tile_m | output | LIN_W | Row tile index bm |
| out_tile_n | output | LIN_W | Column tile index bn |
| out_m_local | output | log2(BLOCK_M) | Row within the tile |
| out_k_local | output | log2(BLOCK_K) | Column within the reduction step |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The coordinates are kept in rolling counters, not recomputed by division. A counter that slips by one therefore corrupts every later address of the run. The error shows at the ports on the first beat after the faulty carry, which is at most BLOCK_K beats after a column rollover or one row after a row rollover. A fault in the tile order shows at the first tile boundary, as a wrong tile index and a wrong address on the first beat of that tile. A fault in the M or K limits flips the element flag on the first ragged-edge beat of the first edge tile. Every accepted beat is compared against a model that divides directly. Hold behaviour under random backpressure is checked on every stalled cycle.

// File: rtl/igemm_pkg.sv
// Shared widths, configuration and position types for the convolution
// operand address sequencer. Assumes unsigned configuration values.
package igemm_pkg;

    parameter int DIM_W  = 8;   // width of one configuration dimension
    parameter int LIN_W  = 20;  // width of linear row/column indices and tile indices
    parameter int ADDR_W = 32;  // width of the emitted input address

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Full configuration as captured at start.
    typedef struct packed {
        logic [DIM_W-1:0] batch;
        logic [DIM_W-1:0] cin;
        logic [DIM_W-1:0] cout;
        logic [DIM_W-1:0] dp;
        logic [DIM_W-1:0] hp;
        logic [DIM_W-1:0] wp;
        logic [DIM_W-1:0] kd;
        logic [DIM_W-1:0] kh;
        logic [DIM_W-1:0] kw;
        logic [DIM_W-1:0] sd;
        logic [DIM_W-1:0] sh;
        logic [DIM_W-1:0] sw;
        logic [DIM_W-1:0] dd;
        logic [DIM_W-1:0] dh;
        logic [DIM_W-1:0] dw;
        logic [DIM_W-1:0] od;
        logic [DIM_W-1:0] oh;
        logic [DIM_W-1:0] ow;
    } cfg_t;

    // Geometry needed after setup by the walker and the address stage.
    typedef struct packed {
        logic [DIM_W-1:0] wp;
        logic [DIM_W-1:0] kd;
        logic [DIM_W-1:0] kh;
        logic [DIM_W-1:0] kw;
        logic [DIM_W-1:0] sd;
        logic [DIM_W-1:0] sh;
        logic [DIM_W-1:0] sw;
        logic [DIM_W-1:0] dd;
        logic [DIM_W-1:0] dh;
        logic [DIM_W-1:0] dw;
        logic [DIM_W-1:0] od;
        logic [DIM_W-1:0] oh;
        logic [DIM_W-1:0] ow;
    } geo_t;

    // Mixed-radix position: lo is the fastest digit, hi is unbounded.
    typedef struct packed {
        logic [LIN_W-1:0] lin;
        logic [LIN_W-1:0] hi;
        logic [DIM_W-1:0] mid2;
        logic [DIM_W-1:0] mid1;
        logic [DIM_W-1:0] lo;
    } pos_t;

    // Advance a position by one with carries at the three bounded extents.
    function automatic pos_t pos_step(input pos_t p,
                                      input logic [DIM_W-1:0] ext_lo,
                                      input logic [DIM_W-1:0] ext_mid1,
                                      input logic [DIM_W-1:0] ext_mid2);
        pos_t r;
        r     = p;
        r.lin = p.lin + LIN_W'(1);
        if (p.lo + DIM_W'(1) == ext_lo) begin
            r.lo = '0;
            if (p.mid1 + DIM_W'(1) == ext_mid1) begin
                r.mid1 = '0;
                if (p.mid2 + DIM_W'(1) == ext_mid2) begin
                    r.mid2 = '0;
                    r.hi   = p.hi + LIN_W'(1);
                end else begin
                    r.mid2 = p.mid2 + DIM_W'(1);
                end
            end else begin
                r.mid1 = p.mid1 + DIM_W'(1);
            end
        end else begin
            r.lo = p.lo + DIM_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/igemm_setup.sv
// Configuration capture and derived constants.
// Captures the configuration on 'capture'. One cycle later it holds the
// problem sizes M and K, the tile grid extents, the reduction step count
// and the plane strides used by the address stage.
// Assumes BLOCK_M, BLOCK_N and BLOCK_K are powers of two and no extent is zero.
module igemm_setup
    import igemm_pkg::*;
#(
    parameter int BLOCK_M = 4,
    parameter int BLOCK_N = 4,
    parameter int BLOCK_K = 4,
    localparam int BM_LOG = $clog2(BLOCK_M),
    localparam int BN_LOG = $clog2(BLOCK_N),
    localparam int BK_LOG = $clog2(BLOCK_K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  cfg_t              cfg_in,
    output geo_t              geo,
    output logic [LIN_W-1:0]  tot_m,
    output logic [LIN_W-1:0]  tot_k,
    output logic [LIN_W-1:0]  grid_m,
    output logic [LIN_W-1:0]  grid_n,
    output logic [LIN_W-1:0]  n_ksteps,
    output logic [ADDR_W-1:0] plane_hw,
    output logic [ADDR_W-1:0] plane_dhw,
    output logic [ADDR_W-1:0] plane_cdhw
);

    cfg_t              cfg_q;
    logic [LIN_W-1:0]  m_c, k_c;
    logic [ADDR_W-1:0] hw_c, dhw_c, cdhw_c;

    // Hold the configuration seen with an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (capture) cfg_q <= cfg_in;
    end

    // Problem sizes and plane strides from the captured configuration.
    always_comb begin
        m_c    = LIN_W'(cfg_q.batch) * LIN_W'(cfg_q.od) * LIN_W'(cfg_q.oh) * LIN_W'(cfg_q.ow);
        k_c    = LIN_W'(cfg_q.cin) * LIN_W'(cfg_q.kd) * LIN_W'(cfg_q.kh) * LIN_W'(cfg_q.kw);
        hw_c   = ADDR_W'(cfg_q.hp) * ADDR_W'(cfg_q.wp);
        dhw_c  = hw_c * ADDR_W'(cfg_q.dp);
        cdhw_c = dhw_c * ADDR_W'(cfg_q.cin);
    end

    // Register the derived constants; they settle during the setup cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_m      <= '0;
            tot_k      <= '0;
            grid_m     <= '0;
            grid_n     <= '0;
            n_ksteps   <= '0;
            plane_hw   <= '0;
            plane_dhw  <= '0;
            plane_cdhw <= '0;
        end else begin
            tot_m      <= m_c;
            tot_k      <= k_c;
            grid_m     <= (m_c + LIN_W'(BLOCK_M - 1)) >> BM_LOG;
            grid_n     <= (LIN_W'(cfg_q.cout) + LIN_W'(BLOCK_N - 1)) >> BN_LOG;
            n_ksteps   <= (k_c + LIN_W'(BLOCK_K - 1)) >> BK_LOG;
            plane_hw   <= hw_c;
            plane_dhw  <= dhw_c;
            plane_cdhw <= cdhw_c;
        end
    end

    // Geometry forwarded to the walker and the address stage.
    always_comb begin
        geo.wp = cfg_q.wp;
        geo.kd = cfg_q.kd;
        geo.kh = cfg_q.kh;
        geo.kw = cfg_q.kw;
        geo.sd = cfg_q.sd;
        geo.sh = cfg_q.sh;
        geo.sw = cfg_q.sw;
        geo.dd = cfg_q.dd;
        geo.dh = cfg_q.dh;
        geo.dw = cfg_q.dw;
        geo.od = cfg_q.od;
        geo.oh = cfg_q.oh;
        geo.ow = cfg_q.ow;
    end

endmodule

// File: rtl/igemm_walker.sv
// Tile and element sequencer.
// Visits row/column tiles in grouped order and skips row tiles past the
// grid. Inside a tile it walks reduction steps, rows, then columns. Row and
// column coordinates are kept as rolling mixed-radix counters with saved
// bases, so no division is used. One beat is offered per cycle in RUN and
// advances on out_ready.
// Assumes GROUP, BLOCK_M and BLOCK_K are powers of two, at least 2.
module igemm_walker
    import igemm_pkg::*;
#(
    parameter int BLOCK_M = 4,
    parameter int BLOCK_K = 4,
    parameter int GROUP   = 8,
    localparam int ML_W = $clog2(BLOCK_M),
    localparam int KL_W = $clog2(BLOCK_K),
    localparam int GS_W = $clog2(GROUP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    input  logic [DIM_W-1:0] ext_ow,
    input  logic [DIM_W-1:0] ext_oh,
    input  logic [DIM_W-1:0] ext_od,
    input  logic [DIM_W-1:0] ext_kw,
    input  logic [DIM_W-1:0] ext_kh,
    input  logic [DIM_W-1:0] ext_kd,
    input  logic [LIN_W-1:0] grid_m,
    input  logic [LIN_W-1:0] grid_n,
    input  logic [LIN_W-1:0] n_ksteps,
    output logic             capture,
    output logic             out_valid,
    output logic             done,
    output pos_t             pos_m,
    output pos_t             pos_k,
    output logic [LIN_W-1:0] tile_m,
    output logic [LIN_W-1:0] tile_n,
    output logic [ML_W-1:0]  m_loc,
    output logic [KL_W-1:0]  k_loc
);

    seq_state_e       st;
    logic [LIN_W-1:0] grp_bm, kstep;
    logic [GS_W-1:0]  slot;
    pos_t             base_m, grp_m, base_k;
    pos_t             row_nx, col_nx;
    logic             fire, end_row, end_step, end_ksteps;
    logic             more_in_grp, more_bn, more_grp, last_beat;

    // Next positions and boundary decisions of the current beat.
    always_comb begin
        row_nx      = pos_step(pos_m, ext_ow, ext_oh, ext_od);
        col_nx      = pos_step(pos_k, ext_kw, ext_kh, ext_kd);
        fire        = (st == ST_RUN) && out_ready;
        end_row     = (k_loc == KL_W'(BLOCK_K - 1));
        end_step    = (m_loc == ML_W'(BLOCK_M - 1));
        end_ksteps  = (kstep == n_ksteps - LIN_W'(1));
        more_in_grp = (slot != GS_W'(GROUP - 1)) && ((tile_m + LIN_W'(1)) < grid_m);
        more_bn     = (tile_n + LIN_W'(1)) < grid_n;
        more_grp    = (slot == GS_W'(GROUP - 1)) && ((tile_m + LIN_W'(1)) < grid_m);
        last_beat   = end_row && end_step && end_ksteps && !more_in_grp && !more_bn && !more_grp;
        capture     = (st == ST_IDLE) && start;
        out_valid   = (st == ST_RUN);
    end

    // Run state and the end-of-run pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            done <= 1'b0;
        end else begin
            done <= fire && last_beat;
            case (st)
                ST_IDLE:  if (start) st <= ST_SETUP;
                ST_SETUP: st <= ST_RUN;
                ST_RUN:   if (fire && last_beat) st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // Tile indices, reduction step, local indices and coordinate counters.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_SETUP) begin
            tile_m <= '0;
            tile_n <= '0;
            grp_bm <= '0;
            slot   <= '0;
            kstep  <= '0;
            m_loc  <= '0;
            k_loc  <= '0;
            pos_m  <= '0;
            base_m <= '0;
            grp_m  <= '0;
            pos_k  <= '0;
            base_k <= '0;
        end else if (fire) begin
            if (!end_row) begin
                k_loc <= k_loc + KL_W'(1);
                pos_k <= col_nx;
            end else begin
                k_loc <= '0;
                if (!end_step) begin
                    m_loc <= m_loc + ML_W'(1);
                    pos_m <= row_nx;
                    pos_k <= base_k;
                end else begin
                    m_loc <= '0;
                    if (!end_ksteps) begin
                        kstep  <= kstep + LIN_W'(1);
                        pos_m  <= base_m;
                        pos_k  <= col_nx;
                        base_k <= col_nx;
                    end else begin
                        kstep  <= '0;
                        pos_k  <= '0;
                        base_k <= '0;
                        if (more_in_grp) begin
                            tile_m <= tile_m + LIN_W'(1);
                            slot   <= slot + GS_W'(1);
                            pos_m  <= row_nx;
                            base_m <= row_nx;
                        end else if (more_bn) begin
                            tile_n <= tile_n + LIN_W'(1);
                            tile_m <= grp_bm;
                            slot   <= '0;
                            pos_m  <= grp_m;
                            base_m <= grp_m;
                        end else if (more_grp) begin
                            tile_n <= '0;
                            tile_m <= tile_m + LIN_W'(1);
                            grp_bm <= tile_m + LIN_W'(1);
                            slot   <= '0;
                            pos_m  <= row_nx;
                            base_m <= row_nx;
                            grp_m  <= row_nx;
                        end
                    end
                end
            end
        end
    end

    // R3: the offered tile always lies inside the grid.
    a_r3_tile_in_grid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tile_m < grid_m) && (tile_n < grid_n));

    // R5: the rolling row counter agrees with tile index and local row.
    a_r5_row_matches_tile: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pos_m.lin == LIN_W'(tile_m * LIN_W'(BLOCK_M) + LIN_W'(m_loc)));

    // R5: the row digits recombine to the linear row index.
    a_r5_row_digits: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pos_m.lin == LIN_W'(((pos_m.hi * LIN_W'(ext_od) + LIN_W'(pos_m.mid2))
                                           * LIN_W'(ext_oh) + LIN_W'(pos_m.mid1))
                                           * LIN_W'(ext_ow) + LIN_W'(pos_m.lo)));

    // R6: the rolling column counter agrees with step and local column.
    a_r6_col_matches_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pos_k.lin == LIN_W'(kstep * LIN_W'(BLOCK_K) + LIN_W'(k_loc)));

    // R4: inside a row the local column advances by one per accepted beat.
    a_r4_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !end_row) |=> k_loc == KL_W'($past(k_loc) + KL_W'(1)));

    // R2: a start during a run never re-enters setup.
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && start) |=> st != ST_SETUP);

endmodule

// File: rtl/igemm_addr_calc.sv
// Address stage: maps the current row and column coordinates to an
// input coordinate with stride and dilation, then to a linear address.
// It also flags elements outside M or K, whose address is forced to zero.
// Purely combinational; assumes the padded volume fits in ADDR_W bits.
module igemm_addr_calc
    import igemm_pkg::*;
(
    input  pos_t              pos_m,
    input  pos_t              pos_k,
    input  logic [LIN_W-1:0]  tot_m,
    input  logic [LIN_W-1:0]  tot_k,
    input  logic [DIM_W-1:0]  wp,
    input  logic [DIM_W-1:0]  sd,
    input  logic [DIM_W-1:0]  sh,
    input  logic [DIM_W-1:0]  sw,
    input  logic [DIM_W-1:0]  dd,
    input  logic [DIM_W-1:0]  dh,
    input  logic [DIM_W-1:0]  dw,
    input  logic [ADDR_W-1:0] plane_hw,
    input  logic [ADDR_W-1:0] plane_dhw,
    input  logic [ADDR_W-1:0] plane_cdhw,
    output logic [ADDR_W-1:0] addr,
    output logic              elem_ok
);

    logic [ADDR_W-1:0] in_d, in_h, in_w, raw;

    // Input coordinates, linear address and the bounds flag.
    always_comb begin
        in_d    = ADDR_W'(pos_m.mid2) * ADDR_W'(sd) + ADDR_W'(pos_k.mid2) * ADDR_W'(dd);
        in_h    = ADDR_W'(pos_m.mid1) * ADDR_W'(sh) + ADDR_W'(pos_k.mid1) * ADDR_W'(dh);
        in_w    = ADDR_W'(pos_m.lo)   * ADDR_W'(sw) + ADDR_W'(pos_k.lo)   * ADDR_W'(dw);
        raw     = ADDR_W'(pos_m.hi) * plane_cdhw + ADDR_W'(pos_k.hi) * plane_dhw
                + in_d * plane_hw + in_h * ADDR_W'(wp) + in_w;
        elem_ok = (pos_m.lin < tot_m) && (pos_k.lin < tot_k);
        addr    = elem_ok ? raw : '0;
    end

endmodule

// File: rtl/igemm_addr_gen.sv
// Top of the convolution operand address sequencer.
// Captures the configuration on start, derives sizes in one setup cycle,
// then streams one beat per accepted handshake: tile indices, local indices,
// the input address and the element flag. Ends with a one-cycle done pulse.
// Assumes power-of-two tile sizes and group size, and nonzero extents.
module igemm_addr_gen
    import igemm_pkg::*;
#(
    parameter int BLOCK_M = 4,
    parameter int BLOCK_N = 4,
    parameter int BLOCK_K = 4,
    parameter int GROUP   = 8,
    localparam int ML_W = $clog2(BLOCK_M),
    localparam int KL_W = $clog2(BLOCK_K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_batch,
    input  logic [DIM_W-1:0]  cfg_cin,
    input  logic [DIM_W-1:0]  cfg_cout,
    input  logic [DIM_W-1:0]  cfg_dp,
    input  logic [DIM_W-1:0]  cfg_hp,
    input  logic [DIM_W-1:0]  cfg_wp,
    input  logic [DIM_W-1:0]  cfg_kd,
    input  logic [DIM_W-1:0]  cfg_kh,
    input  logic [DIM_W-1:0]  cfg_kw,
    input  logic [DIM_W-1:0]  cfg_sd,
    input  logic [DIM_W-1:0]  cfg_sh,
    input  logic [DIM_W-1:0]  cfg_sw,
    input  logic [DIM_W-1:0]  cfg_dd,
    input  logic [DIM_W-1:0]  cfg_dh,
    input  logic [DIM_W-1:0]  cfg_dw,
    input  logic [DIM_W-1:0]  cfg_od,
    input  logic [DIM_W-1:0]  cfg_oh,
    input  logic [DIM_W-1:0]  cfg_ow,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_elem_ok,
    output logic [LIN_W-1:0]  out_tile_m,
    output logic [LIN_W-1:0]  out_tile_n,
    output logic [ML_W-1:0]   out_m_local,
    output logic [KL_W-1:0]   out_k_local,
    output logic              done
);

    cfg_t              cfg_in;
    geo_t              geo;
    logic              capture;
    logic [LIN_W-1:0]  tot_m, tot_k, grid_m, grid_n, n_ksteps;
    logic [ADDR_W-1:0] plane_hw, plane_dhw, plane_cdhw;
    pos_t              pos_m, pos_k;

    // Gather the configuration ports into one record.
    always_comb begin
        cfg_in.batch = cfg_batch;
        cfg_in.cin   = cfg_cin;
        cfg_in.cout  = cfg_cout;
        cfg_in.dp    = cfg_dp;
        cfg_in.hp    = cfg_hp;
        cfg_in.wp    = cfg_wp;
        cfg_in.kd    = cfg_kd;
        cfg_in.kh    = cfg_kh;
        cfg_in.kw    = cfg_kw;
        cfg_in.sd    = cfg_sd;
        cfg_in.sh    = cfg_sh;
        cfg_in.sw    = cfg_sw;
        cfg_in.dd    = cfg_dd;
        cfg_in.dh    = cfg_dh;
        cfg_in.dw    = cfg_dw;
        cfg_in.od    = cfg_od;
        cfg_in.oh    = cfg_oh;
        cfg_in.ow    = cfg_ow;
    end

    igemm_setup #(
        .BLOCK_M (BLOCK_M),
        .BLOCK_N (BLOCK_N),
        .BLOCK_K (BLOCK_K)
    ) setup_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cfg_in     (cfg_in),
        .geo        (geo),
        .tot_m      (tot_m),
        .tot_k      (tot_k),
        .grid_m     (grid_m),
        .grid_n     (grid_n),
        .n_ksteps   (n_ksteps),
        .plane_hw   (plane_hw),
        .plane_dhw  (plane_dhw),
        .plane_cdhw (plane_cdhw)
    );

    igemm_walker #(
        .BLOCK_M (BLOCK_M),
        .BLOCK_K (BLOCK_K),
        .GROUP   (GROUP)
    ) walker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .out_ready (out_ready),
        .ext_ow    (geo.ow),
        .ext_oh    (geo.oh),
        .ext_od    (geo.od),
        .ext_kw    (geo.kw),
        .ext_kh    (geo.kh),
        .ext_kd    (geo.kd),
        .grid_m    (grid_m),
        .grid_n    (grid_n),
        .n_ksteps  (n_ksteps),
        .capture   (capture),
        .out_valid (out_valid),
        .done      (done),
        .pos_m     (pos_m),
        .pos_k     (pos_k),
        .tile_m    (out_tile_m),
        .tile_n    (out_tile_n),
        .m_loc     (out_m_local),
        .k_loc     (out_k_local)
    );

    igemm_addr_calc addr_i (
        .pos_m      (pos_m),
        .pos_k      (pos_k),
        .tot_m      (tot_m),
        .tot_k      (tot_k),
        .wp         (geo.wp),
        .sd         (geo.sd),
        .sh         (geo.sh),
        .sw         (geo.sw),
        .dd         (geo.dd),
        .dh         (geo.dh),
        .dw         (geo.dw),
        .plane_hw   (plane_hw),
        .plane_dhw  (plane_dhw),
        .plane_cdhw (plane_cdhw),
        .addr       (out_addr),
        .elem_ok    (out_elem_ok)
    );

    // R9: a stalled beat holds every field.
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_elem_ok)
            && $stable(out_tile_m) && $stable(out_tile_n)
            && $stable(out_m_local) && $stable(out_k_local));

    // R10: done never coincides with a beat on offer.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R10: done lasts a single cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an element outside the problem never carries an address.
    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_elem_ok) |-> out_addr == '0);

endmodule

// File: tb/igemm_addr_gen_tb_top.sv
// Self-checking bench: random and directed convolution shapes, random
// backpressure and stray start pulses, compared against a dividing model.
module igemm_addr_gen_tb_top;
    import igemm_pkg::*;

    localparam int BM = 4;
    localparam int BN = 4;
    localparam int BK = 4;
    localparam int GS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic out_ready = 1'b0;
    cfg_t drv;
    cfg_t rc;
    logic              out_valid, out_elem_ok, done;
    logic [ADDR_W-1:0] out_addr;
    logic [LIN_W-1:0]  out_tile_m, out_tile_n;
    logic [1:0]        out_m_local, out_k_local;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    igemm_addr_gen #(.BLOCK_M(BM), .BLOCK_N(BN), .BLOCK_K(BK), .GROUP(GS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_batch(drv.batch), .cfg_cin(drv.cin), .cfg_cout(drv.cout),
        .cfg_dp(drv.dp), .cfg_hp(drv.hp), .cfg_wp(drv.wp),
        .cfg_kd(drv.kd), .cfg_kh(drv.kh), .cfg_kw(drv.kw),
        .cfg_sd(drv.sd), .cfg_sh(drv.sh), .cfg_sw(drv.sw),
        .cfg_dd(drv.dd), .cfg_dh(drv.dh), .cfg_dw(drv.dw),
        .cfg_od(drv.od), .cfg_oh(drv.oh), .cfg_ow(drv.ow),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_elem_ok(out_elem_ok), .out_tile_m(out_tile_m), .out_tile_n(out_tile_n),
        .out_m_local(out_m_local), .out_k_local(out_k_local), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Model of address and element flag by direct division.
    function automatic longint model_addr(input int m, input int k, input int bigm,
                                          input int bigk, output bit ok);
        int odhw, ohw, kdhw, khw, n, od, oh, ow, c, kd, kh, kw, id, ih, iw;
        ok = (m < bigm) && (k < bigk);
        if (!ok) return 0;
        ohw  = rc.oh * rc.ow;
        odhw = rc.od * ohw;
        khw  = rc.kh * rc.kw;
        kdhw = rc.kd * khw;
        n  = m / odhw;  od = (m % odhw) / ohw;  oh = (m % ohw) / rc.ow;  ow = m % rc.ow;
        c  = k / kdhw;  kd = (k % kdhw) / khw;  kh = (k % khw) / rc.kw;  kw = k % rc.kw;
        id = od * rc.sd + kd * rc.dd;
        ih = oh * rc.sh + kh * rc.dh;
        iw = ow * rc.sw + kw * rc.dw;
        return ((((longint'(n) * rc.cin + c) * rc.dp + id) * rc.hp + ih) * rc.wp + iw);
    endfunction

    // Wait for one accepted beat under random backpressure; check holds (R9).
    task automatic take_beat();
        bit have_hold = 0;
        logic [ADDR_W-1:0] h_addr;
        logic [LIN_W-1:0] h_tm;
        logic [1:0] h_ml, h_kl;
        forever begin
            @(negedge clk);
            start = ($urandom_range(0, 40) == 0);
            if (start) drv.od = drv.od + 8'd1;
            out_ready = ($urandom_range(0, 3) != 0);
            if (out_valid) begin
                if (have_hold) begin
                    chk(out_addr == h_addr && out_tile_m == h_tm && out_m_local == h_ml
                        && out_k_local == h_kl, "R9 hold under stall", out_addr, h_addr);
                end
                if (out_ready) return;
                have_hold = 1;
                h_addr = out_addr; h_tm = out_tile_m; h_ml = out_m_local; h_kl = out_k_local;
            end
        end
    endtask

    task automatic run_case();
        int bigm, bigk, gm, gn, nks, ngrp, bm, m, k;
        bit eok;
        longint ea;
        bigm = rc.batch * rc.od * rc.oh * rc.ow;
        bigk = rc.cin * rc.kd * rc.kh * rc.kw;
        gm   = (bigm + BM - 1) / BM;
        gn   = (rc.cout + BN - 1) / BN;
        nks  = (bigk + BK - 1) / BK;
        ngrp = (gm + GS - 1) / GS;
        @(negedge clk);
        drv = rc; start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(out_valid == 1'b0, "R2 setup cycle idle", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 first beat timing", out_valid, 1);
        for (int g = 0; g < ngrp; g++)
            for (int bn = 0; bn < gn; bn++)
                for (int s = 0; s < GS; s++) begin
                    bm = g * GS + s;
                    if (bm < gm) begin
                        for (int ks = 0; ks < nks; ks++)
                            for (int ml = 0; ml < BM; ml++)
                                for (int kl = 0; kl < BK; kl++) begin
                                    m = bm * BM + ml;
                                    k = ks * BK + kl;
                                    ea = model_addr(m, k, bigm, bigk, eok);
                                    take_beat();
                                    chk(out_tile_m == LIN_W'(bm), "R3 tile_m", out_tile_m, bm);
                                    chk(out_tile_n == LIN_W'(bn), "R3 tile_n", out_tile_n, bn);
                                    chk(out_m_local == 2'(ml) && out_k_local == 2'(kl),
                                        "R4 local indices", {out_m_local, out_k_local}, (ml << 2) | kl);
                                    chk(out_elem_ok == eok, "R8 R11 element flag", out_elem_ok, eok);
                                    chk(out_addr == ADDR_W'(ea), "R5 R6 R7 address", out_addr, ea);
                                end
                    end
                end
        @(negedge clk);
        start = 1'b0; out_ready = 1'b0;
        chk(done == 1'b1 && out_valid == 1'b0, "R10 done after last beat", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", done, 0);
    endtask

    function automatic cfg_t rand_cfg();
        cfg_t c;
        c.batch = 8'($urandom_range(1, 2));
        c.cin   = 8'($urandom_range(1, 2));
        c.cout  = 8'($urandom_range(1, 9));
        c.kd = 8'($urandom_range(1, 3)); c.kh = 8'($urandom_range(1, 3)); c.kw = 8'($urandom_range(1, 3));
        c.sd = 8'($urandom_range(1, 2)); c.sh = 8'($urandom_range(1, 2)); c.sw = 8'($urandom_range(1, 2));
        c.dd = 8'($urandom_range(1, 2)); c.dh = 8'($urandom_range(1, 2)); c.dw = 8'($urandom_range(1, 2));
        c.od = 8'($urandom_range(1, 3)); c.oh = 8'($urandom_range(1, 3)); c.ow = 8'($urandom_range(1, 4));
        c.dp = (c.od - 8'd1) * c.sd + (c.kd - 8'd1) * c.dd + 8'd1 + 8'($urandom_range(0, 1));
        c.hp = (c.oh - 8'd1) * c.sh + (c.kh - 8'd1) * c.dh + 8'd1 + 8'($urandom_range(0, 1));
        c.wp = (c.ow - 8'd1) * c.sw + (c.kw - 8'd1) * c.dw + 8'd1 + 8'($urandom_range(0, 1));
        return c;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        drv = '0;
        rc  = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs in reset", {out_valid, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 idle after reset", {out_valid, done}, 0);

        // Directed: single element problem, one tile of mostly invalid pairs.
        rc = '{batch:1, cin:1, cout:1, dp:1, hp:1, wp:1, kd:1, kh:1, kw:1,
               sd:1, sh:1, sw:1, dd:1, dh:1, dw:1, od:1, oh:1, ow:1};
        run_case();
        // Directed: ten row tiles, second group partly skipped (R3).
        rc = '{batch:2, cin:2, cout:5, dp:2, hp:2, wp:7, kd:1, kh:1, kw:3,
               sd:1, sh:1, sw:1, dd:1, dh:1, dw:1, od:2, oh:2, ow:5};
        run_case();
        // Directed: exactly one full group, mixed stride and dilation.
        rc = '{batch:1, cin:1, cout:4, dp:4, hp:6, wp:8, kd:2, kh:2, kw:2,
               sd:2, sh:1, sw:2, dd:1, dh:2, dw:1, od:2, oh:4, ow:4};
        run_case();
        // Constrained random shapes.
        for (int i = 0; i < 5; i++) begin
            rc = rand_cfg();
            run_case();
        end

        summary();
        $finish;
    end

endmodule